// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers thirty-two level-sensitive interrupt sources for a primary interrupt controller. Every clock it samples the source levels into a raw-level register and holds an enable mask. All enabled sources are ORed into one summary request, which drives the top line (line 31) of a 32-bit output vector. Sources 21 to 30 can also be routed straight to their own output lines, whatever the mask holds. A direct-routing enable register selects which of those sources are routed.

Software reaches the block through a word-addressed register window of 4 KB on a simple memory-mapped bus. The word index is the byte address shifted right by two. Enables are changed only through separate set and clear words, so a write never has to read the register first. A soft-interrupt word pair acts on enable bit 0. The block has no state machine. Its behaviour lives in three registers (raw level, enable mask, routing enable) and in one registered output vector.

Top module: `sirq_aggregator`

## Requirements
- R1: A read of word 0 (byte address 0x000) returns the raw level ANDed with the enable mask.
- R2: The source inputs are sampled on every clock edge into the raw level, and a read of word 1 (0x004) returns it.
- R3: A write to word 2 (0x008) ORs the data into the enable mask. A write to word 3 (0x00C) clears each mask bit that is 1 in the data. A read of word 2 returns the mask.
- R4: A read of word 4 (0x010) returns raw level bit 0 in bit 0, with zeros above. A nonzero write to word 4 sets mask bit 0, and a nonzero write to word 5 (0x014) clears it. A zero write to either word changes nothing.
- R5: A write to word 8 (0x020) ORs the data ANDed with 0x7FE00000 into the routing enable, so only bits 21 to 30 can become 1. A write to word 9 (0x024) clears the routing bits that are 1 in the data. A read of word 8 returns the routing enable.
- R6: Output line 31 is high exactly when the raw level ANDed with the mask is nonzero.
- R7: For each source 21 to 30 whose routing bit is 1, the output line with the same number equals that source's raw level.
- R8: Output lines 0 to 20 are always low, and a line 21 to 30 whose routing bit is 0 is low.
- R9: Reads of any word other than 0, 1, 2, 4 and 8 return zero. Writes to any word other than 2, 3, 4, 5, 8 and 9 change no state.
- R10: Reset clears the raw level, the mask, the routing enable and the output vector to zero.
- R11: The output vector is registered. It shows the stored state one clock after that state changes, so a source change reaches the output on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Interrupt source levels |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_out | output | 32 | Line 31 is the summary; lines 21 to 30 carry routed sources |

## Verification
The assertions assume that the bus strobe, write flag, address and write data are stable across each rising edge. They also assume that a write lasts a single cycle, so the effect on the next cycle comes from exactly one transfer. The stimulus changes every input only on the falling edge, and it raises the write strobe for one cycle per write. The output checks wait for two rising edges after a source or register change. This keeps them clear of the one-cycle gap between the stored state and the registered output.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        W_STATUS  = 12'd0,
        W_RAW     = 12'd1,
        W_EN_SET  = 12'd2,
        W_EN_CLR  = 12'd3,
        W_SOFT_ON = 12'd4,
        W_SOFT_OF = 12'd5,
        W_RT_SET  = 12'd8,
        W_RT_CLR  = 12'd9
    } word_e;

    function automatic logic [DATA_W-1:0] range_mask(input int lo, input int hi);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++)
            if (i >= lo && i <= hi) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int RT_LO = 21,
    parameter int RT_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] word,
    input  logic [N_SRC-1:0]  wdata,
    output logic [N_SRC-1:0]  level_q,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  rt_q
);
    localparam logic [N_SRC-1:0] RT_ALLOWED = N_SRC'(range_mask(RT_LO, RT_HI));

    logic wdata_nz;
    assign wdata_nz = |wdata;

    logic known_wr;
    always_comb begin
        known_wr = 1'b0;
        if (wr_stb) begin
            unique case (word)
                W_EN_SET, W_EN_CLR, W_SOFT_ON, W_SOFT_OF, W_RT_SET, W_RT_CLR: known_wr = 1'b1;
                default: known_wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            mask_q  <= '0;
            rt_q    <= '0;
        end else begin
            level_q <= src_lvl;
            if (known_wr) begin
                unique case (word)
                    W_EN_SET:  mask_q <= mask_q | wdata;
                    W_EN_CLR:  mask_q <= mask_q & ~wdata;
                    W_SOFT_ON: if (wdata_nz) mask_q[0] <= 1'b1;
                    W_SOFT_OF: if (wdata_nz) mask_q[0] <= 1'b0;
                    W_RT_SET:  rt_q <= rt_q | (wdata & RT_ALLOWED);
                    W_RT_CLR:  rt_q <= rt_q & ~wdata;
                    default:   mask_q <= mask_q;
                endcase
            end
        end
    end

    // R3: set word leaves every written bit enabled
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word == W_EN_SET) |=> ((mask_q & $past(wdata)) == $past(wdata)));
    // R3: clear word leaves no written bit enabled
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word == W_EN_CLR) |=> ((mask_q & $past(wdata)) == '0));
    // R4: nonzero soft-on write enables bit 0
    a_r4_soft_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word == W_SOFT_ON && wdata != '0) |=> mask_q[0]);
    // R5: routing enable never holds a bit outside the allowed range
    a_r5_rt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q & ~RT_ALLOWED) == '0);
    // R9: writes to unknown words change no state
    a_r9_ignore_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !known_wr) |=> ($stable(mask_q) && $stable(rt_q)));
endmodule

// File: rtl/sirq_rdmux.sv
module sirq_rdmux
    import sirq_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic [ADDR_W-1:0] word,
    input  logic [N_SRC-1:0]  level_q,
    input  logic [N_SRC-1:0]  mask_q,
    input  logic [N_SRC-1:0]  rt_q,
    output logic [N_SRC-1:0]  rdata
);
    always_comb begin
        unique case (word)
            W_STATUS:  rdata = level_q & mask_q;
            W_RAW:     rdata = level_q;
            W_EN_SET:  rdata = mask_q;
            W_SOFT_ON: rdata = {{(N_SRC-1){1'b0}}, level_q[0]};
            W_RT_SET:  rdata = rt_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/sirq_outgen.sv
module sirq_outgen #(
    parameter int N_SRC = 32,
    parameter int RT_LO = 21,
    parameter int RT_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] level_q,
    input  logic [N_SRC-1:0] mask_q,
    input  logic [N_SRC-1:0] rt_q,
    output logic [N_SRC-1:0] irq_q
);
    localparam int SUM_LINE = N_SRC - 1;

    logic [N_SRC-1:0] irq_d;

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        if (i == SUM_LINE) begin : g_sum
            assign irq_d[i] = |(level_q & mask_q);
            // R6: summary line follows the masked state one cycle later
            a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
                ((level_q & mask_q) != '0) |=> irq_q[i]);
        end else if (i >= RT_LO && i <= RT_HI) begin : g_route
            assign irq_d[i] = level_q[i] & rt_q[i];
            // R7: a routed line copies its source level
            a_r7_route: assert property (@(posedge clk) disable iff (!rst_n)
                rt_q[i] |=> (irq_q[i] == $past(level_q[i])));
        end else begin : g_low
            assign irq_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator
    import sirq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int RT_LO = 21,
    parameter int RT_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic [N_SRC-1:0]  irq_out
);
    logic [ADDR_W-1:0] word;
    logic              wr_stb;
    logic [N_SRC-1:0]  level_q, mask_q, rt_q;

    assign word   = bus_addr >> 2;
    assign wr_stb = bus_sel & bus_wr;

    sirq_regs #(.N_SRC(N_SRC), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_stb(wr_stb),
        .word(word), .wdata(bus_wdata),
        .level_q(level_q), .mask_q(mask_q), .rt_q(rt_q)
    );

    sirq_rdmux #(.N_SRC(N_SRC)) u_rdmux (
        .word(word), .level_q(level_q), .mask_q(mask_q), .rt_q(rt_q),
        .rdata(bus_rdata)
    );

    sirq_outgen #(.N_SRC(N_SRC), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_out (
        .clk(clk), .rst_n(rst_n), .level_q(level_q), .mask_q(mask_q),
        .rt_q(rt_q), .irq_q(irq_out)
    );

    // R10: one cycle after reset the output vector is clear
    a_r10_reset_out: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/test_sirq_aggregator.sv
module test_sirq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sirq_aggregator i_sirq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] src;
        logic [31:0] exp_rd;
        logic [31:0] exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        {1'b1, 12'h008, 32'h0000_0011, 32'h0000_0000, 32'h0, 32'h0000_0000, 4'd3},  // R3 set
        {1'b0, 12'h008, 32'h0,         32'h0000_0000, 32'h0000_0011, 32'h0, 4'd3},  // R3 read
        {1'b0, 12'h004, 32'h0,         32'h0000_0010, 32'h0000_0010, 32'h8000_0000, 4'd2}, // R2 raw, R6
        {1'b0, 12'h000, 32'h0,         32'h0000_0013, 32'h0000_0011, 32'h8000_0000, 4'd1}, // R1
        {1'b1, 12'h00C, 32'h0000_0010, 32'h0000_0012, 32'h0, 32'h0000_0000, 4'd3},  // R3 clear
        {1'b0, 12'h000, 32'h0,         32'h0000_0013, 32'h0000_0001, 32'h8000_0000, 4'd1}, // R1
        {1'b0, 12'h010, 32'h0,         32'h0000_0013, 32'h0000_0001, 32'h8000_0000, 4'd4}, // R4 read
        {1'b1, 12'h014, 32'h0000_0008, 32'h0000_0013, 32'h0, 32'h0000_0000, 4'd4},  // R4 soft off
        {1'b0, 12'h008, 32'h0,         32'h0000_0013, 32'h0000_0000, 32'h0, 4'd4},  // R4
        {1'b1, 12'h010, 32'h0000_0100, 32'h0000_0013, 32'h0, 32'h8000_0000, 4'd4},  // R4 soft on
        {1'b1, 12'h014, 32'h0000_0000, 32'h0000_0013, 32'h0, 32'h8000_0000, 4'd4},  // R4 zero write
        {1'b1, 12'h010, 32'h0000_0000, 32'h0000_0012, 32'h0, 32'h0000_0000, 4'd6},  // R6 low
        {1'b0, 12'h008, 32'h0,         32'h0000_0012, 32'h0000_0001, 32'h0, 4'd4},  // R4
        {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'h0000_0000, 4'd5},  // R5 set
        {1'b0, 12'h020, 32'h0,         32'hFFFF_FFFF, 32'h7FE0_0000, 32'hFFE0_0000, 4'd7}, // R5, R7
        {1'b1, 12'h024, 32'h0020_0000, 32'hFFFF_FFFF, 32'h0, 32'hFFC0_0000, 4'd8},  // R8 route off
        {1'b0, 12'h020, 32'h0,         32'h4000_0000, 32'h7FC0_0000, 32'h4000_0000, 4'd7}, // R7
        {1'b1, 12'h018, 32'hFFFF_FFFF, 32'h4000_0000, 32'h0, 32'h4000_0000, 4'd9},  // R9 ignored
        {1'b0, 12'h008, 32'h0,         32'h8000_0001, 32'h0000_0001, 32'h8000_0000, 4'd9}, // R9
        {1'b0, 12'h00C, 32'h0,         32'h0000_0000, 32'h0000_0000, 32'h0, 4'd9},  // R9 read
        {1'b0, 12'h024, 32'h0,         32'h0000_0000, 32'h0000_0000, 32'h0, 4'd9},  // R9 read
        {1'b0, 12'hFFC, 32'h0,         32'h0000_0000, 32'h0000_0000, 32'h0, 4'd9},  // R9 read
        {1'b1, 12'h008, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h8000_0000, 4'd3},  // R3, R8
        {1'b0, 12'h000, 32'h0,         32'h8020_0000, 32'h8000_0000, 32'h8000_0000, 4'd8}  // R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        // R10: held in reset with all sources high
        src_lvl = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10 irq in reset", irq_out, 32'h0);
        rd_word(12'h004, v); check("R10 raw in reset", v, 32'h0);
        rd_word(12'h008, v); check("R10 mask in reset", v, 32'h0);
        rd_word(12'h020, v); check("R10 route in reset", v, 32'h0);
        src_lvl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d entry %0d", TBL[k].req, k);
            src_lvl = TBL[k].src;
            if (TBL[k].wr) begin
                bus_sel = 1'b1; bus_wr = 1'b1;
                bus_addr = TBL[k].addr; bus_wdata = TBL[k].data;
            end
            @(posedge clk);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            if (!TBL[k].wr) begin
                rd_word(TBL[k].addr, v);
                check({tag, " read"}, v, TBL[k].exp_rd);
            end
            @(posedge clk);
            @(negedge clk);
            check({tag, " irq"}, irq_out, TBL[k].exp_irq);
        end

        // R11: latency; mask is 0x80000001 here
        src_lvl = 32'h0000_0000;
        repeat (2) @(negedge clk);
        src_lvl = 32'h0000_0001;
        @(negedge clk);
        rd_word(12'h004, v);
        check("R11 raw after one edge", v, 32'h0000_0001);
        check("R11 irq not yet", irq_out, 32'h0);
        @(negedge clk);
        check("R11 irq after two edges", irq_out, 32'h8000_0000);

        // R8: route lines low when routing cleared, low lines stay low
        wr_word(12'h024, 32'hFFFF_FFFF);
        src_lvl = 32'h7FFF_FFFE;
        repeat (2) @(negedge clk);
        check("R8 all low", irq_out, 32'h0);

        // R10: reset mid-run clears stored state
        wr_word(12'h020, 32'h7FE0_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        src_lvl = '0;
        rd_word(12'h008, v); check("R10 mask after reset", v, 32'h0);
        rd_word(12'h020, v); check("R10 route after reset", v, 32'h0);
        check("R10 irq after reset", irq_out, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule